// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two independent 16-bit counters that sit on a processor's special-function-register bus. Each counter is kept as a low byte and a high byte, and software can read and write both. A control register and a mode register configure the counters. Each channel counts one of two sources: every system clock, or the falling edges of its own external count pin. A channel runs when software sets its run bit. In gated mode it also needs its external interrupt pin to be high.

When a counter rolls over from all ones to zero, it raises an overflow flag. The flag stays set until the interrupt controller acknowledges that timer, or until software clears it. The same control register also holds the edge-flag bits and the edge/level select bits for two active-low external interrupt inputs. A per-input strobe from the interrupt controller clears the matching edge flag. The control register can be written as a whole byte or one bit at a time. The mode register holds two mode bits per channel, which are stored and read back. Counting is always 16 bits wide, whatever those bits hold.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, the control register, the mode register and all four counter bytes read 0, and `tmr_flag_o` and `ext_flag_o` are both 0.
- R2: Register map. Control register at 0x88, bits 7..0 = {ovf1, run1, ovf0, run0, eflag1, emode1, eflag0, emode0}. Mode register at 0x89, bits 7..0 = {gate1, src1, mode1[1:0], gate0, src0, mode0[1:0]}. Low bytes are at 0x8A (ch0) and 0x8B (ch1). High bytes are at 0x8C (ch0) and 0x8D (ch1). Every other address reads 0.
- R3: A bit write (`sfr_bit_wr_i`) changes only the control-register bit chosen by `sfr_bit_sel_i` and leaves the other seven bits unchanged.
- R4: With src=0 and gate=0, a running channel increments once per clock. With run=0 the counter holds its value.
- R5: With src=1, the counter increments once for each falling edge of its count pin, after a two-flop synchronizer. Rising edges do not count.
- R6: With gate=1, the channel counts only while its synchronized interrupt pin is high. While the pin is low, the counter holds even with run=1.
- R7: An increment from 0xFFFF gives 0x0000 and sets that channel's overflow flag, which appears on `tmr_flag_o[c]`.
- R8: `tmr_ack_i[c]` clears only overflow flag c. A software write of 0 also clears it. An overflow in the same cycle wins over both, and an acknowledge wins over a software write.
- R9: A CPU write to either byte of a counter wins over a hardware increment in the same cycle. The whole counter skips that increment.
- R10: With emode=1, a synchronized falling edge on interrupt pin c sets eflag c. The flag stays set until `ext_ack_i[c]` or a software write of 0. An edge in the same cycle wins over both.
- R11: With emode=0, eflag c follows the inverted synchronized pin level: 1 while the pin is low, 0 while it is high. Software writes to it have no effect.
- R12: `ext_ack_i[c]` clears only edge flag c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | Register address for reads and byte writes |
| sfr_wr_i | input | 1 | Byte write strobe |
| sfr_wdata_i | input | 8 | Byte write data |
| sfr_bit_wr_i | input | 1 | Single-bit write strobe, control register |
| sfr_bit_sel_i | input | 3 | Bit index for a bit write |
| sfr_bit_val_i | input | 1 | Value for a bit write |
| sfr_rdata_o | output | 8 | Combinational read data |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| irq_pin_i | input | 2 | Active-low external interrupt pins, also the gates |
| tmr_ack_i | input | 2 | Overflow interrupt acknowledge strobes |
| ext_ack_i | input | 2 | External interrupt acknowledge strobes |
| tmr_flag_o | output | 2 | Overflow flags |
| ext_flag_o | output | 2 | External interrupt flags |

## Verification
The counter is driven from free clock ticks over a fixed number of enabled edges, and the exact count shows whether the start and stop edges are included. It is then driven from pulses on the count pin, where the count has to equal the number of falling edges rather than the number of cycles the pin spends low. A gated run is tried with the interrupt pin held low and then held high, which separates gate-blocked holds from ordinary counting. Preloading the counter near all ones and writing a byte while the counter runs show up wrap, flag-setting and write-priority faults as distinct wrong values.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int unsigned N_CH = 2;
  localparam logic [7:0] ADDR_CTRL = 8'h88;
  localparam logic [7:0] ADDR_MODE = 8'h89;
  localparam logic [7:0] ADDR_LO_BASE = 8'h8A;
  localparam logic [7:0] ADDR_HI_BASE = 8'h8C;

  typedef struct packed {
    logic       gate;
    logic       src;
    logic [1:0] mode;
  } ch_mode_t;
endpackage

// File: rtl/dtu_sync.sv
module dtu_sync #(
  parameter int unsigned N = 1,
  parameter int unsigned STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {(STAGES*N){RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             gate_i,
  input  logic             src_i,
  input  logic             cnt_s_i,
  input  logic             gate_s_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             flag_we_i,
  input  logic             flag_wv_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_o,
  output logic             flag_o
);
  localparam int unsigned HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             cnt_prev;
  logic             evt;
  logic             enabled;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  assign evt     = src_i ? (cnt_prev & ~cnt_s_i) : 1'b1;
  assign enabled = run_i & (~gate_i | gate_s_i);
  // CPU byte write suppresses the whole increment
  assign inc_o   = enabled & evt & ~(lo_we_i | hi_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_prev <= 1'b1;
    else         cnt_prev <= cnt_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (lo_we_i || hi_we_i) begin
      if (lo_we_i) cnt_q[HALF-1:0]     <= wdata_i[HALF-1:0];
      if (hi_we_i) cnt_q[CNT_W-1:HALF] <= wdata_i[HALF-1:0];
    end else if (inc_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          flag_q <= 1'b0;
    else if (inc_o && cnt_q == CNT_MAX)   flag_q <= 1'b1;
    else if (ack_i)                       flag_q <= 1'b0;
    else if (flag_we_i)                   flag_q <= flag_wv_i;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dtu_ext_irq.sv
module dtu_ext_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic edge_mode_i,
  input  logic sw_we_i,
  input  logic sw_wv_i,
  input  logic ack_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic fall;

  assign fall = prev_q & ~pin_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (!edge_mode_i) flag_q <= ~pin_s_i;  // level: tracks pin, not latched
    else if (fall)        flag_q <= 1'b1;
    else if (ack_i)       flag_q <= 1'b0;
    else if (sw_we_i)     flag_q <= sw_wv_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      sfr_addr_i,
  input  logic            sfr_wr_i,
  input  logic [7:0]      sfr_wdata_i,
  input  logic            sfr_bit_wr_i,
  input  logic [2:0]      sfr_bit_sel_i,
  input  logic            sfr_bit_val_i,
  output logic [7:0]      sfr_rdata_o,
  input  logic [N_CH-1:0] cnt_pin_i,
  input  logic [N_CH-1:0] irq_pin_i,
  input  logic [N_CH-1:0] tmr_ack_i,
  input  logic [N_CH-1:0] ext_ack_i,
  output logic [N_CH-1:0] tmr_flag_o,
  output logic [N_CH-1:0] ext_flag_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [N_CH-1:0]            cnt_s, irq_s;
  logic [7:0]                 ctrl_mask, ctrl_wv, ctrl_rd;
  logic [N_CH-1:0][3:0]       mode_q;
  ch_mode_t [N_CH-1:0]        ch_mode;
  logic [N_CH-1:0]            run_q, emode_q;
  logic [N_CH-1:0]            lo_we, hi_we, inc;
  logic [N_CH-1:0]            tf_we, tf_wv, ie_we, ie_wv;
  logic [N_CH-1:0][CNT_W-1:0] cnt_val;
  logic                       ctrl_byte_wr, mode_wr;

  dtu_sync #(.N(N_CH), .STAGES(2), .RST_VAL(1'b1)) u_sync_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_pin_i), .q_o(cnt_s)
  );
  dtu_sync #(.N(N_CH), .STAGES(2), .RST_VAL(1'b1)) u_sync_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_pin_i), .q_o(irq_s)
  );

  assign ctrl_byte_wr = sfr_wr_i && (sfr_addr_i == ADDR_CTRL);
  assign mode_wr      = sfr_wr_i && (sfr_addr_i == ADDR_MODE);

  // byte write has priority over a bit write in the same cycle
  always_comb begin
    ctrl_mask = '0;
    ctrl_wv   = '0;
    if (ctrl_byte_wr) begin
      ctrl_mask = '1;
      ctrl_wv   = sfr_wdata_i;
    end else if (sfr_bit_wr_i) begin
      ctrl_mask = 8'(1) << sfr_bit_sel_i;
      ctrl_wv   = {8{sfr_bit_val_i}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_wr) mode_q <= sfr_wdata_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned RUN_B = 4 + 2 * c;
    localparam int unsigned TF_B  = 5 + 2 * c;
    localparam int unsigned IT_B  = 2 * c;
    localparam int unsigned IE_B  = 2 * c + 1;

    assign ch_mode[c] = mode_q[c];
    assign lo_we[c]   = sfr_wr_i && (sfr_addr_i == ADDR_LO_BASE + 8'(c));
    assign hi_we[c]   = sfr_wr_i && (sfr_addr_i == ADDR_HI_BASE + 8'(c));
    assign tf_we[c]   = ctrl_mask[TF_B];
    assign tf_wv[c]   = ctrl_wv[TF_B];
    assign ie_we[c]   = ctrl_mask[IE_B];
    assign ie_wv[c]   = ctrl_wv[IE_B];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[c]   <= 1'b0;
        emode_q[c] <= 1'b0;
      end else begin
        if (ctrl_mask[RUN_B]) run_q[c]   <= ctrl_wv[RUN_B];
        if (ctrl_mask[IT_B])  emode_q[c] <= ctrl_wv[IT_B];
      end
    end

    dtu_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q[c]),
      .gate_i   (ch_mode[c].gate),
      .src_i    (ch_mode[c].src),
      .cnt_s_i  (cnt_s[c]),
      .gate_s_i (irq_s[c]),
      .lo_we_i  (lo_we[c]),
      .hi_we_i  (hi_we[c]),
      .wdata_i  (sfr_wdata_i),
      .flag_we_i(tf_we[c]),
      .flag_wv_i(tf_wv[c]),
      .ack_i    (tmr_ack_i[c]),
      .cnt_o    (cnt_val[c]),
      .inc_o    (inc[c]),
      .flag_o   (tmr_flag_o[c])
    );

    dtu_ext_irq u_ext (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_s_i    (irq_s[c]),
      .edge_mode_i(emode_q[c]),
      .sw_we_i    (ie_we[c]),
      .sw_wv_i    (ie_wv[c]),
      .ack_i      (ext_ack_i[c]),
      .flag_o     (ext_flag_o[c])
    );
  end

  always_comb begin
    ctrl_rd = '0;
    for (int c = 0; c < N_CH; c++) begin
      ctrl_rd[4 + 2*c] = run_q[c];
      ctrl_rd[5 + 2*c] = tmr_flag_o[c];
      ctrl_rd[2*c]     = emode_q[c];
      ctrl_rd[2*c + 1] = ext_flag_o[c];
    end
  end

  always_comb begin
    sfr_rdata_o = '0;
    if (sfr_addr_i == ADDR_CTRL) sfr_rdata_o = ctrl_rd;
    if (sfr_addr_i == ADDR_MODE) sfr_rdata_o = mode_q;
    for (int c = 0; c < N_CH; c++) begin
      if (sfr_addr_i == ADDR_LO_BASE + 8'(c)) sfr_rdata_o = cnt_val[c][HALF-1:0];
      if (sfr_addr_i == ADDR_HI_BASE + 8'(c)) sfr_rdata_o = cnt_val[c][CNT_W-1:HALF];
    end
  end
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1,
  input logic [1:0]  inc,
  input logic [1:0]  run,
  input logic [1:0]  emode,
  input logic [1:0]  irq_s,
  input logic [1:0]  lo_we,
  input logic [1:0]  hi_we,
  input logic [1:0]  ie_we,
  input logic        gate0,
  input logic [1:0]  tmr_ack,
  input logic [1:0]  ext_ack,
  input logic [1:0]  tmr_flag,
  input logic [1:0]  ext_flag
);
  p_ovf_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[0] && cnt0 == 16'hFFFF) |=> (tmr_flag[0] && cnt0 == 16'h0000));

  p_ovf_flag1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[1] && cnt1 == 16'hFFFF) |=> (tmr_flag[1] && cnt1 == 16'h0000));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run[0] && !lo_we[0] && !hi_we[0]) |=> $stable(cnt0));

  p_hold1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run[1] && !lo_we[1] && !hi_we[1]) |=> $stable(cnt1));

  p_gate_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate0 && !irq_s[0] && !lo_we[0] && !hi_we[0]) |=> $stable(cnt0));

  p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_ack[0] && !(inc[0] && cnt0 == 16'hFFFF)) |=> !tmr_flag[0]);

  p_level_track_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emode[0] |=> (ext_flag[0] == !$past(irq_s[0])));

  p_edge_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emode[1] && ext_flag[1] && !ext_ack[1] && !ie_we[1]) |=> ext_flag[1]);

  p_ext_ack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emode[0] && ext_ack[0] && irq_s[0]) |=> !ext_flag[0]);
endmodule

bind dual_timer_unit dtu_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt0    (cnt_val[0]),
  .cnt1    (cnt_val[1]),
  .inc     (inc),
  .run     (run_q),
  .emode   (emode_q),
  .irq_s   (irq_s),
  .lo_we   (lo_we),
  .hi_we   (hi_we),
  .ie_we   (ie_we),
  .gate0   (ch_mode[0].gate),
  .tmr_ack (tmr_ack_i),
  .ext_ack (ext_ack_i),
  .tmr_flag(tmr_flag_o),
  .ext_flag(ext_flag_o)
);

// File: tb/dual_timer_unit_bench.sv
`timescale 1ns/1ps
module dual_timer_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sfr_addr_i = '0;
  logic       sfr_wr_i = 1'b0;
  logic [7:0] sfr_wdata_i = '0;
  logic       sfr_bit_wr_i = 1'b0;
  logic [2:0] sfr_bit_sel_i = '0;
  logic       sfr_bit_val_i = 1'b0;
  logic [7:0] sfr_rdata_o;
  logic [1:0] cnt_pin_i = 2'b11;
  logic [1:0] irq_pin_i = 2'b11;
  logic [1:0] tmr_ack_i = '0;
  logic [1:0] ext_ack_i = '0;
  logic [1:0] tmr_flag_o;
  logic [1:0] ext_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dual_timer_unit u_dual_timer_unit (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    sfr_addr_i = a; sfr_wdata_i = d; sfr_wr_i = 1'b1;
    @(negedge clk_i);
    sfr_wr_i = 1'b0;
  endtask

  task automatic wbit(logic [2:0] idx, logic v);
    @(negedge clk_i);
    sfr_bit_sel_i = idx; sfr_bit_val_i = v; sfr_bit_wr_i = 1'b1;
    @(negedge clk_i);
    sfr_bit_wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sfr_addr_i = a;
    #1 d = sfr_rdata_o;
  endtask

  task automatic rd16(int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(8'h8A + 8'(ch), lo);
    rd(8'h8C + 8'(ch), hi);
    v = {hi, lo};
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 8'h88; a <= 8'h8D; a++) begin
      rd(8'(a), d);
      check("R1 reg after reset", {8'h0, d}, 16'h0);
    end
    check("R1 flags after reset", {12'h0, tmr_flag_o, ext_flag_o}, 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(8'h89, 8'hA5);
    rd(8'h89, d);
    check("R2 mode readback", {8'h0, d}, 16'h00A5);
    wr(8'h89, 8'h00);
    wr(8'h8B, 8'h3C);
    wr(8'h8D, 8'hC3);
    rd(8'h8B, d);
    check("R2 lo1 readback", {8'h0, d}, 16'h003C);
    rd(8'h8D, d);
    check("R2 hi1 readback", {8'h0, d}, 16'h00C3);
    rd(8'h90, d);
    check("R2 unmapped reads 0", {8'h0, d}, 16'h0);
    wbit(3'd2, 1'b1);
    rd(8'h88, d);
    check("R3 bit write sets one bit", {8'h0, d}, 16'h0004);
    wbit(3'd2, 1'b0);
    rd(8'h88, d);
    check("R3 bit write clears one bit", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_internal();
    logic [15:0] v;
    wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    wbit(3'd4, 1'b1);
    idle(10);
    wbit(3'd4, 1'b0);
    rd16(0, v);
    check("R4 internal clock count", v, 16'd12);
    idle(5);
    rd16(0, v);
    check("R4 halted counter holds", v, 16'd12);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(8'h8A, 8'hF8); wr(8'h8C, 8'hFF);
    check("R7 flag clear before wrap", {14'h0, tmr_flag_o}, 16'h0);
    wbit(3'd4, 1'b1);
    idle(10);
    wbit(3'd4, 1'b0);
    rd16(0, v);
    check("R7 wrap value", v, 16'h0004);
    check("R7 overflow flag set", {14'h0, tmr_flag_o}, 16'h0001);
  endtask

  task automatic t_ack();
    wbit(3'd7, 1'b1);
    check("R8 sw set flag1", {14'h0, tmr_flag_o}, 16'h0003);
    @(negedge clk_i); tmr_ack_i = 2'b01;
    @(negedge clk_i); tmr_ack_i = 2'b00;
    check("R8 ack0 clears only flag0", {14'h0, tmr_flag_o}, 16'h0002);
    wbit(3'd7, 1'b0);
    check("R8 sw write clears flag1", {14'h0, tmr_flag_o}, 16'h0000);
  endtask

  task automatic t_write_wins();
    logic [15:0] v;
    wr(8'h8B, 8'h00); wr(8'h8D, 8'h00);
    wbit(3'd6, 1'b1);
    idle(3);
    wr(8'h8B, 8'hF0);
    wbit(3'd6, 1'b0);
    rd16(1, v);
    check("R9 byte write wins over increment", v, 16'h00F2);
  endtask

  task automatic t_ext_src();
    logic [15:0] v;
    wr(8'h89, 8'h04);
    wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    wbit(3'd4, 1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); cnt_pin_i[0] = 1'b0;
      idle(3);
      cnt_pin_i[0] = 1'b1;
      idle(3);
    end
    idle(4);
    wbit(3'd4, 1'b0);
    rd16(0, v);
    check("R5 falling edges counted", v, 16'd5);
    @(negedge clk_i); cnt_pin_i[0] = 1'b0;
    idle(3); cnt_pin_i[0] = 1'b1; idle(5);
    rd16(0, v);
    check("R4 halted ignores pin edges", v, 16'd5);
    wr(8'h89, 8'h00);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    wr(8'h89, 8'h08);
    @(negedge clk_i); irq_pin_i[0] = 1'b0;
    idle(4);
    wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    wbit(3'd4, 1'b1);
    idle(10);
    wbit(3'd4, 1'b0);
    rd16(0, v);
    check("R6 gate low blocks count", v, 16'd0);
    @(negedge clk_i); irq_pin_i[0] = 1'b1;
    idle(4);
    wbit(3'd4, 1'b1);
    idle(10);
    wbit(3'd4, 1'b0);
    rd16(0, v);
    check("R6 gate high counts", v, 16'd12);
    wr(8'h89, 8'h00);
    idle(4);
  endtask

  task automatic t_edge_irq();
    logic [7:0] d;
    wbit(3'd0, 1'b1);
    wbit(3'd2, 1'b1);
    wbit(3'd1, 1'b0);
    wbit(3'd3, 1'b0);
    check("R10 edge flags clear", {14'h0, ext_flag_o}, 16'h0);
    @(negedge clk_i); irq_pin_i = 2'b00;
    idle(3);
    irq_pin_i = 2'b11;
    idle(6);
    check("R10 edge flags latched", {14'h0, ext_flag_o}, 16'h0003);
    rd(8'h88, d);
    check("R10 ctrl shows flags", {8'h0, d}, 16'h000F);
    @(negedge clk_i); ext_ack_i = 2'b01;
    @(negedge clk_i); ext_ack_i = 2'b00;
    check("R12 ext ack0 clears only flag0", {14'h0, ext_flag_o}, 16'h0002);
    wbit(3'd3, 1'b0);
    check("R10 sw write clears edge flag", {14'h0, ext_flag_o}, 16'h0000);
  endtask

  task automatic t_level_irq();
    wbit(3'd2, 1'b0);
    @(negedge clk_i); irq_pin_i[1] = 1'b0;
    idle(5);
    check("R11 level low sets flag", {15'h0, ext_flag_o[1]}, 16'h1);
    wbit(3'd3, 1'b0);
    check("R11 sw write ignored in level mode", {15'h0, ext_flag_o[1]}, 16'h1);
    irq_pin_i[1] = 1'b1;
    idle(5);
    check("R11 level high clears flag", {15'h0, ext_flag_o[1]}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_internal();
    t_overflow();
    t_ack();
    t_write_wins();
    t_ext_src();
    t_gate();
    t_edge_irq();
    t_level_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule